// File: doc/BRIEF.md
# Output Port Transmit Word Formatter

This block decides, once per word slot, which 34-bit word leaves one output port of a serial crosspoint switch. A word is two overhead bits followed by a 32-bit body. The body of a command word holds a five-bit command code, eleven zero filler bits and a 16-bit payload. The formatter takes the word that the crossbar selected for the port and sorts it by its overhead bits and command code. It then passes the word on, rewrites it, or replaces it with a word of its own: an IDLE filler, an ALIGN training word or a command to the far-end transceiver.

IDLE words carry information. In packet mode the IDLE payload reports which outputs this port currently drives, with port 0 in the top payload bit. In cell mode the payload holds the default pattern. The last IDLE of each cell period can be tagged as a cell boundary marker.

Both data interfaces are valid/ready. An input word transfers on a rising edge where `in_valid` and `in_ready` are both high. The output register loads a new word on any edge where `out_ready` is high or `out_valid` is low. While the output is stalled, the word and its kind hold, and `in_ready` stays low so no input word is lost. `in_ready` does not depend on `in_valid`.

Top module: `tx_word_formatter`

## Requirements
- R1: During reset `out_valid` is 0 and `out_word` is all zeros. At the first rising edge after reset is released, `out_valid` rises and then stays high.
- R2: While `out_valid` is 1 and `out_ready` is 0, `out_word` and `out_kind` hold and `in_ready` is 0. When the output loads, a word accepted at that edge appears on `out_word` after the same edge.
- R3: An accepted word is passed on unchanged, and `out_kind` reports its class:
  - overhead 01 or 10 gives flow-control kind 6;
  - overhead 11 gives header kind 7;
  - overhead 00 with code 00000 gives ALIGN kind 0;
  - overhead 00 with code 00xxx other than 00000 and 00111 gives link kind 2;
  - overhead 00 with code 01xx0 gives transceiver kind 3;
  - overhead 00 with code 10xx0 gives switch kind 4;
  - overhead 00 with code 11xx0 gives port-card kind 5.
- R4: A word with overhead 00 whose code has a top pair other than 00 and a bottom bit of 1 is invalid. It is still consumed, and an IDLE word is sent in its place.
- R5: In packet mode (`cell_mode`=0) every IDLE word sent has payload bit 15-i equal to `conn_map[i]`. This includes an IDLE word (code 00111) arriving at the input, whose payload is replaced.
- R6: In cell mode every IDLE word sent carries payload 0xAAAA.
- R7: In cell mode a high `force_idle` makes the port send IDLE with `in_ready` at 0. In packet mode `force_idle` has no effect.
- R8: When `cell_mode`, `cell_mark_en` and `slot_last` are all high at the loading edge, an IDLE sent in that slot carries overhead 11. Any other word, and any IDLE sent in packet mode, keeps its own overhead.
- R9: When input is eligible but `in_valid` is 0, an IDLE word (kind 1, overhead 00 unless marked) is sent. An IDLE word is laid out as code 00111, filler zero and the payload.
- R10: With `out_en` at 0 the port sends IDLE with a zero payload and overhead 00, and `in_ready` is 0. This overrides every other request.
- R11: With `align_req` high (and `out_en` high) the port sends ALIGN, with code 00000 and payload 0xAAAA. This takes priority over `xcmd_req`, and `in_ready` is 0.
- R12: With `xcmd_req` high (and no ALIGN request) the port sends transceiver command 01000 with payload {0xAAA, `xcmd_val`}, kind 3. This takes priority over `force_idle`, and `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cell_mode | input | 1 | 1 = cell mode, 0 = packet mode |
| cell_mark_en | input | 1 | Enables the cell boundary marker on IDLE words |
| slot_last | input | 1 | The loading slot is the last one of the cell period |
| force_idle | input | 1 | Forces IDLE words in cell mode |
| out_en | input | 1 | Output enable; 0 logically disables the port |
| align_req | input | 1 | Request to send ALIGN training words |
| xcmd_req | input | 1 | Request to send the transceiver delay/clock command |
| xcmd_val | input | 4 | Value carried in the transceiver command |
| conn_map | input | NPORTS | Outputs driven by this port; bit i stands for port i |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Formatter accepts the input word at this edge |
| in_word | input | 34 | Word selected by the crossbar |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Serializer takes the output word |
| out_word | output | 34 | Word to transmit |
| out_kind | output | 4 | Class of `out_word` (encodings as in R3, IDLE = 1) |

## Verification
The assertions assume that every control input is settled before the rising edge at which the output loads, because the cell marker check looks back one cycle at `cell_mode`, `cell_mark_en` and `slot_last`. They also assume that `conn_map` bits above the port count are meaningless. The stimulus changes every input only on falling edges, so each control value is stable across the edge that uses it. Stalls are made by holding `out_ready` low for whole cycles. All stimulus uses the default of sixteen ports.

// File: rtl/tx_fmt_pkg.sv
package tx_fmt_pkg;
  localparam int OVH_W  = 2;
  localparam int CODE_W = 5;
  localparam int PAY_W  = 16;
  localparam int FILL_W = 11;
  localparam int BODY_W = CODE_W + FILL_W + PAY_W;
  localparam int WORD_W = OVH_W + BODY_W;

  localparam logic [CODE_W-1:0] CODE_ALIGN = 5'b00000;
  localparam logic [CODE_W-1:0] CODE_IDLE  = 5'b00111;
  localparam logic [CODE_W-1:0] CODE_XDLY  = 5'b01000;
  localparam logic [PAY_W-1:0]  PAY_DFLT   = 16'hAAAA;

  typedef enum logic [3:0] {
    K_ALIGN  = 4'd0,
    K_IDLE   = 4'd1,
    K_LINK   = 4'd2,
    K_XCVR   = 4'd3,
    K_SWITCH = 4'd4,
    K_CARD   = 4'd5,
    K_FLOW   = 4'd6,
    K_HEADER = 4'd7,
    K_BAD    = 4'd8
  } word_kind_e;

  function automatic logic [WORD_W-1:0] make_cmd(input logic [OVH_W-1:0] ovh,
                                                 input logic [CODE_W-1:0] code,
                                                 input logic [PAY_W-1:0] pay);
    return {ovh, code, {FILL_W{1'b0}}, pay};
  endfunction
endpackage

// File: rtl/tx_fmt_classify.sv
module tx_fmt_classify
  import tx_fmt_pkg::*;
(
  input  logic [OVH_W-1:0]  ovh,
  input  logic [CODE_W-1:0] code,
  output word_kind_e        kind
);
  always_comb begin
    kind = K_BAD;
    unique case (ovh)
      2'b01, 2'b10: kind = K_FLOW;
      2'b11:        kind = K_HEADER;
      default: begin
        unique case (code[4:3])
          2'b00: begin
            if (code == CODE_ALIGN)     kind = K_ALIGN;
            else if (code == CODE_IDLE) kind = K_IDLE;
            else                        kind = K_LINK;
          end
          2'b01: kind = code[0] ? K_BAD : K_XCVR;
          2'b10: kind = code[0] ? K_BAD : K_SWITCH;
          default: kind = code[0] ? K_BAD : K_CARD;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/tx_fmt_idle_gen.sv
module tx_fmt_idle_gen
  import tx_fmt_pkg::*;
#(
  parameter int NPORTS = 16
) (
  input  logic              cell_mode,
  input  logic              mark_now,
  input  logic [NPORTS-1:0] conn_map,
  output logic [WORD_W-1:0] idle_word
);
  logic [PAY_W-1:0] map_rev;
  logic [PAY_W-1:0] pay;
  logic [OVH_W-1:0] ovh;

  genvar gi;
  generate
    for (gi = 0; gi < PAY_W; gi++) begin : g_rev
      if (gi < NPORTS) begin : g_used
        assign map_rev[PAY_W-1-gi] = conn_map[gi];
      end else begin : g_pad
        assign map_rev[PAY_W-1-gi] = 1'b0;
      end
    end
  endgenerate

  assign pay       = cell_mode ? PAY_DFLT : map_rev;
  assign ovh       = (cell_mode && mark_now) ? 2'b11 : 2'b00;
  assign idle_word = make_cmd(ovh, CODE_IDLE, pay);
endmodule

// File: rtl/tx_fmt_select.sv
module tx_fmt_select
  import tx_fmt_pkg::*;
(
  input  logic              out_en,
  input  logic              align_req,
  input  logic              xcmd_req,
  input  logic [3:0]        xcmd_val,
  input  logic              forced,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  word_kind_e        in_kind,
  input  logic [WORD_W-1:0] idle_word,
  output logic              take,
  output logic [WORD_W-1:0] nxt_word,
  output word_kind_e        nxt_kind
);
  always_comb begin
    take     = 1'b0;
    nxt_word = idle_word;
    nxt_kind = K_IDLE;
    if (!out_en) begin
      nxt_word = make_cmd(2'b00, CODE_IDLE, '0);
    end else if (align_req) begin
      nxt_word = make_cmd(2'b00, CODE_ALIGN, PAY_DFLT);
      nxt_kind = K_ALIGN;
    end else if (xcmd_req) begin
      nxt_word = make_cmd(2'b00, CODE_XDLY, {PAY_DFLT[PAY_W-1:4], xcmd_val});
      nxt_kind = K_XCVR;
    end else if (!forced) begin
      take = 1'b1;
      if (in_valid && in_kind != K_BAD && in_kind != K_IDLE) begin
        nxt_word = in_word;
        nxt_kind = in_kind;
      end
    end
  end
endmodule

// File: rtl/tx_word_formatter.sv
module tx_word_formatter
  import tx_fmt_pkg::*;
#(
  parameter int NPORTS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cell_mode,
  input  logic              cell_mark_en,
  input  logic              slot_last,
  input  logic              force_idle,
  input  logic              out_en,
  input  logic              align_req,
  input  logic              xcmd_req,
  input  logic [3:0]        xcmd_val,
  input  logic [NPORTS-1:0] conn_map,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic [3:0]        out_kind
);
  localparam int CODE_LSB = PAY_W + FILL_W;

  word_kind_e        in_kind;
  word_kind_e        nxt_kind;
  logic [WORD_W-1:0] idle_word;
  logic [WORD_W-1:0] nxt_word;
  logic              take;
  logic              load;

  assign load     = out_ready || !out_valid;
  assign in_ready = load && take;

  tx_fmt_classify u_classify (
    .ovh  (in_word[WORD_W-1 -: OVH_W]),
    .code (in_word[CODE_LSB +: CODE_W]),
    .kind (in_kind)
  );

  tx_fmt_idle_gen #(.NPORTS(NPORTS)) u_idle (
    .cell_mode (cell_mode),
    .mark_now  (cell_mark_en && slot_last),
    .conn_map  (conn_map),
    .idle_word (idle_word)
  );

  tx_fmt_select u_select (
    .out_en    (out_en),
    .align_req (align_req),
    .xcmd_req  (xcmd_req),
    .xcmd_val  (xcmd_val),
    .forced    (cell_mode && force_idle),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .in_kind   (in_kind),
    .idle_word (idle_word),
    .take      (take),
    .nxt_word  (nxt_word),
    .nxt_kind  (nxt_kind)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_kind  <= K_ALIGN;
    end else if (load) begin
      out_valid <= 1'b1;
      out_word  <= nxt_word;
      out_kind  <= nxt_kind;
    end
  end

  AST_VALID_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_valid); // R1

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(out_word) && $stable(out_kind))); // R2

  AST_STALL_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R2

  AST_DISABLED_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> !in_ready); // R10

  AST_FORCED_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_mode && force_idle) |-> !in_ready); // R7

  AST_IDLE_LAYOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == K_IDLE) |->
      (out_word[CODE_LSB +: CODE_W] == CODE_IDLE && out_word[PAY_W +: FILL_W] == '0)); // R9

  AST_MARK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == K_IDLE && out_word[WORD_W-1 -: OVH_W] == 2'b11 &&
     $past(out_ready || !out_valid)) |->
      $past(cell_mode && cell_mark_en && slot_last)); // R8
endmodule

// File: tb/test_tx_word_formatter.sv
`timescale 1ns/1ps
module test_tx_word_formatter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cell_mode = 1'b0, cell_mark_en = 1'b0, slot_last = 1'b0, force_idle = 1'b0;
  logic        out_en = 1'b1, align_req = 1'b0, xcmd_req = 1'b0;
  logic [3:0]  xcmd_val = 4'h0;
  logic [15:0] conn_map = 16'h0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [33:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [33:0] out_word;
  logic [3:0]  out_kind;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tx_word_formatter #(.NPORTS(16)) i_tx_word_formatter (
    .clk(clk), .rst_n(rst_n), .cell_mode(cell_mode), .cell_mark_en(cell_mark_en),
    .slot_last(slot_last), .force_idle(force_idle), .out_en(out_en),
    .align_req(align_req), .xcmd_req(xcmd_req), .xcmd_val(xcmd_val),
    .conn_map(conn_map), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word), .out_kind(out_kind)
  );

  function automatic logic [33:0] cw(input logic [1:0] o, input logic [4:0] c,
                                     input logic [15:0] p);
    return {o, c, 11'b0, p};
  endfunction

  typedef struct packed {
    logic        cm, mk, ls, fi, oe, al, xc;
    logic [3:0]  xv;
    logic        iv;
    logic [33:0] w;
    logic [15:0] map;
    logic        er;
    logic [33:0] ew;
    logic [3:0]  ek;
    logic [3:0]  rq;
  } vec_t;

  localparam logic [33:0] DW = {2'b01, 32'h12345678};
  localparam logic [33:0] HW = {2'b11, 32'hDEADBEEF};
  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{0,0,0,0,1,0,0,4'h0,1, DW, 16'h0000, 1, DW, 4'd6, 4'd3},                                        // R3 flow
    '{0,0,0,0,1,0,0,4'h0,1, HW, 16'h0000, 1, HW, 4'd7, 4'd3},                                        // R3 header
    '{0,0,0,0,1,0,0,4'h0,1, cw(2'b00,5'b10010,16'h1234), 16'h0, 1, cw(2'b00,5'b10010,16'h1234), 4'd4, 4'd3}, // R3 switch
    '{0,0,0,0,1,0,0,4'h0,1, cw(2'b00,5'b11000,16'h00FF), 16'h0, 1, cw(2'b00,5'b11000,16'h00FF), 4'd5, 4'd3}, // R3 card
    '{0,0,0,0,1,0,0,4'h0,1, cw(2'b00,5'b01100,16'h0F0F), 16'h0, 1, cw(2'b00,5'b01100,16'h0F0F), 4'd3, 4'd3}, // R3 xcvr
    '{0,0,0,0,1,0,0,4'h0,1, cw(2'b00,5'b00101,16'h7777), 16'h0, 1, cw(2'b00,5'b00101,16'h7777), 4'd2, 4'd3}, // R3 link
    '{0,0,0,0,1,0,0,4'h0,1, cw(2'b00,5'b00000,16'h3C3C), 16'h0, 1, cw(2'b00,5'b00000,16'h3C3C), 4'd0, 4'd3}, // R3 align
    '{0,0,0,0,1,0,0,4'h0,1, cw(2'b00,5'b10011,16'h1111), 16'h0001, 1, cw(2'b00,5'b00111,16'h8000), 4'd1, 4'd4}, // R4
    '{0,0,0,0,1,0,0,4'h0,1, cw(2'b00,5'b01001,16'h2222), 16'h0002, 1, cw(2'b00,5'b00111,16'h4000), 4'd1, 4'd4}, // R4
    '{0,0,0,0,1,0,0,4'h0,0, DW, 16'h8003, 1, cw(2'b00,5'b00111,16'hC001), 4'd1, 4'd9},               // R9
    '{0,0,0,0,1,0,0,4'h0,1, cw(2'b00,5'b00111,16'h5555), 16'h00F0, 1, cw(2'b00,5'b00111,16'h0F00), 4'd1, 4'd5}, // R5
    '{1,0,0,0,1,0,0,4'h0,0, DW, 16'h8003, 1, cw(2'b00,5'b00111,16'hAAAA), 4'd1, 4'd6},               // R6
    '{1,0,0,1,1,0,0,4'h0,1, DW, 16'h0001, 0, cw(2'b00,5'b00111,16'hAAAA), 4'd1, 4'd7},               // R7 forced
    '{0,0,0,1,1,0,0,4'h0,1, DW, 16'h0001, 1, DW, 4'd6, 4'd7},                                        // R7 ignored
    '{1,1,1,0,1,0,0,4'h0,0, DW, 16'h0001, 1, cw(2'b11,5'b00111,16'hAAAA), 4'd1, 4'd8},               // R8 marked
    '{1,1,1,0,1,0,0,4'h0,1, DW, 16'h0001, 1, DW, 4'd6, 4'd8},                                        // R8 data kept
    '{0,1,1,0,1,0,0,4'h0,0, DW, 16'h0001, 1, cw(2'b00,5'b00111,16'h8000), 4'd1, 4'd8},               // R8 packet
    '{1,1,1,1,0,1,1,4'h3,1, DW, 16'hFFFF, 0, cw(2'b00,5'b00111,16'h0000), 4'd1, 4'd10},              // R10
    '{0,0,0,0,1,1,1,4'h5,1, DW, 16'h0001, 0, cw(2'b00,5'b00000,16'hAAAA), 4'd0, 4'd11},              // R11
    '{0,0,0,0,1,0,1,4'h5,1, DW, 16'h0001, 0, cw(2'b00,5'b01000,16'hAAA5), 4'd3, 4'd12},              // R12
    '{1,1,1,1,1,0,1,4'h3,1, DW, 16'h0001, 0, cw(2'b00,5'b01000,16'hAAA3), 4'd3, 4'd12}               // R12 over forced
  };

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    logic [33:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 valid in reset", 64'(out_valid), 64'd0);
    check("R1 word in reset", 64'(out_word), 64'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 valid after reset", 64'(out_valid), 64'd1);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cell_mode = VECS[i].cm; cell_mark_en = VECS[i].mk; slot_last = VECS[i].ls;
      force_idle = VECS[i].fi; out_en = VECS[i].oe; align_req = VECS[i].al;
      xcmd_req = VECS[i].xc; xcmd_val = VECS[i].xv; in_valid = VECS[i].iv;
      in_word = VECS[i].w; conn_map = VECS[i].map;
      #1;
      check($sformatf("R%0d ready v%0d", VECS[i].rq, i), 64'(in_ready), 64'(VECS[i].er));
      @(posedge clk); #1;
      check($sformatf("R%0d word v%0d", VECS[i].rq, i), 64'(out_word), 64'(VECS[i].ew));
      check($sformatf("R%0d kind v%0d", VECS[i].rq, i), 64'(out_kind), 64'(VECS[i].ek));
    end

    // R2: stall holds the word and blocks the input
    @(negedge clk);
    cell_mode = 0; cell_mark_en = 0; slot_last = 0; force_idle = 0; out_en = 1;
    align_req = 0; xcmd_req = 0; conn_map = 16'h0001;
    in_valid = 1; in_word = HW; out_ready = 0;
    held = out_word;
    #1;
    check("R2 ready while stalled", 64'(in_ready), 64'd0);
    @(posedge clk); #1;
    check("R2 word held", 64'(out_word), 64'(held));
    check("R1 valid held", 64'(out_valid), 64'd1);
    @(negedge clk);
    in_word = DW;
    @(posedge clk); #1;
    check("R2 word still held", 64'(out_word), 64'(held));
    @(negedge clk);
    out_ready = 1;
    #1;
    check("R2 ready after release", 64'(in_ready), 64'd1);
    @(posedge clk); #1;
    check("R2 word after release", 64'(out_word), 64'(DW));
    check("R3 kind after release", 64'(out_kind), 64'd6);

    // R1: reset mid-run clears the output
    @(negedge clk);
    rst_n = 0;
    #1;
    check("R1 valid cleared", 64'(out_valid), 64'd0);
    check("R1 word cleared", 64'(out_word), 64'd0);
    @(negedge clk);
    rst_n = 1; in_valid = 0;
    @(posedge clk); #1;
    check("R9 idle after reset", 64'(out_word), 64'(cw(2'b00, 5'b00111, 16'h8000)));

    done = 1'b1;
    finish_run();
  end
endmodule